// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block drives one serial transmit line with a single character at a time. The frame shape is set at run time. The data field is 8 or 9 bits wide. Parity is optional, odd or even, and when it is on it uses the last data position. The stop period can be a half, one, one and a half or two bit times. Bit timing comes from an external tick at 16 times the baud rate, so one bit lasts 16 ticks.

A character is offered on a valid/ready handshake. Two request strobes can replace a normal character with a frame that holds the line high, or with a frame that holds it low. The configuration inputs are sampled when a frame is launched and stay fixed until that frame ends. A busy flag covers the whole frame, and a one-cycle done pulse marks its end.

Top module: `uart_frame_tx`

## Requirements
- R1: Reset behaviour. During and after reset, before any frame is launched, `txd` is 1, `busy` is 0 and `frame_done` is 0. `tx_ready` is 1 whenever neither request strobe is high.
- R2: Data frame. A data frame sends a start bit at 0 and then the data field, least significant bit first. The field is 8 bits when `cfg_len9`=0 and 9 bits when `cfg_len9`=1. Each of these bits lasts 16 ticks of `baud_tick`.
- R3: Parity. When `cfg_par_en`=1, the last position of the data field carries a parity bit instead of the top data bit. That is bit 7 in 8-bit mode and bit 8 in 9-bit mode. The parity covers the 7 or 8 payload bits actually sent: `cfg_par_odd`=1 gives odd parity and 0 gives even parity.
- R4: Stop period. After the data field the line is 1 for a number of ticks set by `cfg_stop`: 2'b00 gives 16, 2'b01 gives 8, 2'b10 gives 32 and 2'b11 gives 24.
- R5: Idle frame. An `idle_req` frame holds `txd` at 1 for exactly as long as a data frame under the sampled settings. That is (1 + data bits) × 16 ticks plus the stop period.
- R6: Break frame. A `break_req` frame holds `txd` at 0 for (1 + data bits) × 16 ticks. It then holds `txd` at 1 for the configured stop period.
- R7: Priority. When the block is not busy, `break_req` beats `idle_req`, and `idle_req` beats `tx_valid`. `tx_ready` is 0 while busy or while either request is high. A character is taken only on a clock edge where both `tx_valid` and `tx_ready` are 1.
- R8: Configuration and requests during a frame. Configuration is captured at launch, so changes made during a frame do not alter that frame. Requests and valid data that arrive while `busy` is 1 are ignored and are not held over.
- R9: End of frame. On the clock edge that ends the last stop tick, `busy` falls and `frame_done` is 1 for exactly one cycle. A new frame may be launched from that same cycle.
- R10: Launch timing. A frame's first element appears on `txd` in the cycle after the launch edge. A tick in the launch cycle itself is not counted toward the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe at 16× the baud rate |
| cfg_len9 | input | 1 | Data field length: 0 = 8 bits, 1 = 9 bits |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Parity sense: 1 = odd, 0 = even |
| cfg_stop | input | 2 | Stop length code |
| tx_data | input | 9 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Character accepted when high with `tx_valid` |
| idle_req | input | 1 | Request an all-high frame |
| break_req | input | 1 | Request a low frame followed by stop |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at end of frame |

## Verification
Some behaviours are checked by assertions on every cycle:
- The line stays high when the block is idle.
- Ready is held low while busy.
- Every accepted character makes the block busy.
- A launch puts the level implied by the request priority on the line at once.
- The done pulse lasts one cycle and coincides with the block going idle.
- The stop period begins only on a tick.

Other behaviours can be shown only by the bench's scenarios, which compare every cycle against a tick-level reference:
- the bit order and parity values;
- the exact tick counts of each stop code and of idle and break frames;
- that configuration changes and strobes made during a frame have no effect.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

   typedef enum logic [1:0] {
      FK_DATA  = 2'd0,
      FK_IDLE  = 2'd1,
      FK_BREAK = 2'd2
   } frame_kind_e;

   typedef struct packed {
      logic       len9;
      logic       par_en;
      logic       par_odd;
      logic [1:0] stop_sel;
   } frame_cfg_t;

   // stop period length in ticks for a given code and oversampling ratio
   function automatic int stop_len(logic [1:0] sel, int ovs);
      case (sel)
         2'b00:   return ovs;
         2'b01:   return ovs / 2;
         2'b10:   return 2 * ovs;
         default: return ovs + ovs / 2;
      endcase
   endfunction

endpackage

// File: rtl/uart_txf_body.sv
module uart_txf_body
   import uart_txf_pkg::*;
#(
   parameter int SHORT_LEN = 8,
   parameter bit PARITY_EN = 1'b1,
   localparam int LONG_LEN = SHORT_LEN + 1,
   localparam int BW       = LONG_LEN + 1,
   localparam int CW       = $clog2(BW + 1)
) (
   input  frame_kind_e         kind,
   input  frame_cfg_t          cfg,
   input  logic [LONG_LEN-1:0] data,
   output logic [BW-1:0]       body,
   output logic [CW-1:0]       body_bits
);

   logic                par_on;
   logic                par_bit;
   logic [LONG_LEN-1:0] pay_mask;
   logic [LONG_LEN-1:0] field;

   // payload positions that are sent as data (parity slot excluded)
   always_comb begin
      int n_dat;
      n_dat = cfg.len9 ? LONG_LEN : SHORT_LEN;
      for (int i = 0; i < LONG_LEN; i++)
         pay_mask[i] = (i < n_dat - (par_on ? 1 : 0));
   end

   generate
      if (PARITY_EN) begin : g_par
         assign par_on  = cfg.par_en;
         assign par_bit = (^(data & pay_mask)) ^ cfg.par_odd;
      end else begin : g_nopar
         assign par_on  = 1'b0;
         assign par_bit = 1'b0;
      end
   endgenerate

   always_comb begin
      int n_dat;
      n_dat = cfg.len9 ? LONG_LEN : SHORT_LEN;
      for (int i = 0; i < LONG_LEN; i++) begin
         if (par_on && i == n_dat - 1) field[i] = par_bit;
         else if (i < n_dat)           field[i] = data[i];
         else                          field[i] = 1'b1;
      end
      body_bits = CW'(n_dat + 1);
      case (kind)
         FK_IDLE:  body = '1;
         FK_BREAK: body = '0;
         default:  body = {field, 1'b0};
      endcase
   end

endmodule

// File: rtl/uart_txf_seq.sv
module uart_txf_seq #(
   parameter int OVS = 16,
   parameter int BW  = 10,
   parameter int CW  = 4,
   parameter int STW = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           launch,
   input  logic [BW-1:0]  body_in,
   input  logic [CW-1:0]  body_bits,
   input  logic [STW-1:0] stop_ticks,
   output logic           line,
   output logic           active,
   output logic           done
);

   localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;

   typedef enum logic [1:0] {S_IDLE, S_BODY, S_STOP} seq_state_e;

   seq_state_e     state;
   logic [BW-1:0]  shreg;
   logic [CW-1:0]  bits_left;
   logic [TW-1:0]  tcnt;
   logic [STW-1:0] scnt;
   logic [STW-1:0] stop_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         shreg     <= '1;
         bits_left <= '0;
         tcnt      <= '0;
         scnt      <= '0;
         stop_lim  <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: if (launch) begin
               shreg     <= body_in;
               bits_left <= body_bits - CW'(1);
               tcnt      <= '0;
               stop_lim  <= stop_ticks - STW'(1);
               state     <= S_BODY;
            end
            S_BODY: if (tick) begin
               if (tcnt == TW'(OVS - 1)) begin
                  tcnt <= '0;
                  if (bits_left == '0) begin
                     state <= S_STOP;
                     scnt  <= '0;
                  end else begin
                     shreg     <= {1'b1, shreg[BW-1:1]};
                     bits_left <= bits_left - CW'(1);
                  end
               end else begin
                  tcnt <= tcnt + TW'(1);
               end
            end
            S_STOP: if (tick) begin
               if (scnt == stop_lim) begin
                  state <= S_IDLE;
                  done  <= 1'b1;
               end else begin
                  scnt <= scnt + STW'(1);
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign line   = (state == S_BODY) ? shreg[0] : 1'b1;
   assign active = (state != S_IDLE);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_STOP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == S_STOP) |-> $past(tick)); // R4

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uart_txf_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int SHORT_LEN = 8,
   parameter bit PARITY_EN = 1'b1,
   localparam int LONG_LEN = SHORT_LEN + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                baud_tick,
   input  logic                cfg_len9,
   input  logic                cfg_par_en,
   input  logic                cfg_par_odd,
   input  logic [1:0]          cfg_stop,
   input  logic [LONG_LEN-1:0] tx_data,
   input  logic                tx_valid,
   output logic                tx_ready,
   input  logic                idle_req,
   input  logic                break_req,
   output logic                txd,
   output logic                busy,
   output logic                frame_done
);

   localparam int BW  = LONG_LEN + 1;
   localparam int CW  = $clog2(BW + 1);
   localparam int STW = $clog2(2 * OVS + 1);

   generate
      if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 2");
      end
      if (SHORT_LEN < 2) begin : g_bad_len
         $error("SHORT_LEN must be at least 2");
      end
   endgenerate

   frame_cfg_t     cfg_live;
   frame_kind_e    kind;
   logic           launch;
   logic [BW-1:0]  body;
   logic [CW-1:0]  body_bits;
   logic [STW-1:0] stop_ticks;

   assign cfg_live   = {cfg_len9, cfg_par_en, cfg_par_odd, cfg_stop};
   assign kind       = break_req ? FK_BREAK : (idle_req ? FK_IDLE : FK_DATA);
   assign tx_ready   = !busy && !idle_req && !break_req;
   assign launch     = !busy && (break_req || idle_req || tx_valid);
   assign stop_ticks = STW'(stop_len(cfg_stop, OVS));

   uart_txf_body #(
      .SHORT_LEN (SHORT_LEN),
      .PARITY_EN (PARITY_EN)
   ) u_body (
      .kind      (kind),
      .cfg       (cfg_live),
      .data      (tx_data),
      .body      (body),
      .body_bits (body_bits)
   );

   uart_txf_seq #(
      .OVS (OVS),
      .BW  (BW),
      .CW  (CW),
      .STW (STW)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (baud_tick),
      .launch     (launch),
      .body_in    (body),
      .body_bits  (body_bits),
      .stop_ticks (stop_ticks),
      .line       (txd),
      .active     (busy),
      .done       (frame_done)
   );

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd); // R1
   AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !tx_ready); // R7
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> busy); // R7
   AST_FIRST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (txd == $past(idle_req && !break_req))); // R10
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (!busy && $past(busy))); // R9

endmodule

// File: tb/uart_frame_tx_bench.sv
`timescale 1ns/1ps
module uart_frame_tx_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       cfg_len9 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic [1:0] cfg_stop = 2'b00;
   logic [8:0] tx_data = '0;
   logic       tx_valid = 1'b0, idle_req = 1'b0, break_req = 1'b0;
   logic       tx_ready, txd, busy, frame_done;

   always #2 clk = ~clk;

   uart_frame_tx u_uart_frame_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_len9(cfg_len9), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_stop(cfg_stop), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .idle_req(idle_req), .break_req(break_req),
      .txd(txd), .busy(busy), .frame_done(frame_done)
   );

   int    n_cmp = 0, n_bad = 0, cyc = 0, n_launch = 0, n_done = 0;
   string tag = "R1";
   bit    finished = 1'b0;
   bit    mq[$];
   bit    m_done = 1'b0;

   // irregular tick pattern
   always @(negedge clk) baud_tick <= (cyc % 3 != 1);

   task automatic check(string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   // level per tick for one frame: kind 0 data, 1 idle, 2 break
   task automatic build(int kind);
      int  nd, sl;
      bit  p;
      bit  lv;
      nd = cfg_len9 ? 9 : 8;
      case (cfg_stop)
         2'b00: sl = 16; 2'b01: sl = 8; 2'b10: sl = 32; default: sl = 24;
      endcase
      p = cfg_par_odd;
      for (int i = 0; i < nd - 1; i++) p ^= tx_data[i];
      for (int b = 0; b <= nd; b++) begin
         if (kind == 1)      lv = 1'b1;
         else if (kind == 2) lv = 1'b0;
         else if (b == 0)    lv = 1'b0;
         else if (cfg_par_en && b == nd) lv = p;
         else                lv = tx_data[b-1];
         for (int t = 0; t < 16; t++) mq.push_back(lv);
      end
      for (int t = 0; t < sl; t++) mq.push_back(1'b1);
      n_launch++;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         mq.delete();
         m_done = 1'b0;
      end else begin
         m_done = 1'b0;
         if (mq.size() == 0) begin
            if (break_req)     build(2);
            else if (idle_req) build(1);
            else if (tx_valid) build(0);
         end else if (baud_tick) begin
            void'(mq.pop_front());
            if (mq.size() == 0) m_done = 1'b1;
         end
      end
      #1;
      if (!finished) begin
         check("txd", txd, (mq.size() != 0) ? mq[0] : 1'b1);
         check("busy", busy, mq.size() != 0);
         check("frame_done", frame_done, m_done);
         check("tx_ready", tx_ready, (mq.size() == 0) && !idle_req && !break_req);
         if (frame_done) n_done++;
      end
      if (cyc > 150000 && !finished) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   task automatic finish_run();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic set_cfg(bit l9, bit pe, bit po, bit [1:0] sp);
      @(negedge clk);
      cfg_len9 = l9; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = sp;
   endtask

   task automatic wait_idle();
      #0.5;
      while (busy) begin @(negedge clk); #0.5; end
   endtask

   task automatic send(logic [8:0] d);
      @(negedge clk);
      tx_valid = 1'b1; tx_data = d;
      #0.5;
      while (!tx_ready) begin @(negedge clk); #0.5; end
      @(negedge clk);
      tx_valid = 1'b0;
      wait_idle();
   endtask

   task automatic request(bit idl, bit brk);
      @(negedge clk);
      idle_req = idl; break_req = brk;
      @(negedge clk);
      idle_req = 1'b0; break_req = 1'b0;
      wait_idle();
   endtask

   initial begin
      tag = "R1";
      repeat (3) @(negedge clk);
      check("reset txd", txd, 1'b1);
      check("reset busy", busy, 1'b0);
      check("reset ready", tx_ready, 1'b1);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      tag = "R2";
      set_cfg(0, 0, 0, 2'b00); send(9'h0A5); send(9'h13C);
      set_cfg(1, 0, 0, 2'b00); send(9'h1A5); send(9'h001);

      tag = "R3";
      set_cfg(0, 1, 0, 2'b00); send(9'h073); send(9'h0FF);
      set_cfg(0, 1, 1, 2'b00); send(9'h073); send(9'h000);
      set_cfg(1, 1, 0, 2'b00); send(9'h1B1);
      set_cfg(1, 1, 1, 2'b00); send(9'h0B1); send(9'h17F);

      tag = "R4";
      set_cfg(0, 0, 0, 2'b01); send(9'h055);
      set_cfg(0, 1, 1, 2'b10); send(9'h0AA);
      set_cfg(1, 0, 0, 2'b11); send(9'h133);

      tag = "R5";
      set_cfg(0, 0, 0, 2'b01); request(1, 0);
      set_cfg(1, 1, 0, 2'b10); request(1, 0);

      tag = "R6";
      set_cfg(0, 0, 0, 2'b00); request(0, 1);
      set_cfg(1, 0, 0, 2'b11); request(0, 1);

      tag = "R7";
      @(negedge clk);
      tx_valid = 1'b1; idle_req = 1'b1; break_req = 1'b1; tx_data = 9'h0F0;
      @(negedge clk);
      tx_valid = 1'b0; idle_req = 1'b0; break_req = 1'b0;
      wait_idle();
      @(negedge clk);
      tx_valid = 1'b1; idle_req = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0; idle_req = 1'b0;
      wait_idle();

      tag = "R8";
      set_cfg(0, 1, 0, 2'b01);
      @(negedge clk);
      tx_valid = 1'b1; tx_data = 9'h0C3;
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (40) @(negedge clk);
      cfg_len9 = 1'b1; cfg_par_en = 1'b0; cfg_stop = 2'b10; tx_data = 9'h1FF;
      idle_req = 1'b1;
      @(negedge clk);
      idle_req = 1'b0; break_req = 1'b1;
      @(negedge clk);
      break_req = 1'b0; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      wait_idle();
      repeat (5) @(negedge clk);
      check("no held-over frame busy", busy, 1'b0);

      tag = "R9";
      set_cfg(0, 0, 1, 2'b01);
      @(negedge clk);
      tx_valid = 1'b1; tx_data = 9'h081;
      repeat (3) begin
         @(negedge clk); #0.5;
         while (!tx_ready) begin @(negedge clk); #0.5; end
      end
      @(negedge clk);
      tx_valid = 1'b0;
      wait_idle();

      tag = "R10";
      set_cfg(1, 1, 1, 2'b11); send(9'h100);
      repeat (4) @(negedge clk);

      tag = "R9";
      check("done pulses equal launches", (n_done == n_launch), 1'b1);
      finish_run();
   end

endmodule